// File: doc/BRIEF.md
# ISA-to-IDE Byte-Pair I/O Bridge

This block connects an 8-bit ISA I/O bus to a 16-bit IDE/ATA drive port. It compares the upper I/O address lines against a base set by four switches, which gives sixteen 32-port windows from 200h to 3E0h. For each hit it drives the drive chip selects and register address, and gates the host read and write strobes through to the drive. A single one-byte holding register lets two back-to-back 8-bit host cycles form one 16-bit drive transfer.

Host reads use the lower half of the window (A4 = 0) and host writes use the upper half (A4 = 1). The chip-select polarity of the data pair is swapped between the halves. On a read the first byte runs the real drive cycle and parks the high byte. On a write the first byte only parks the host byte, and the second byte runs the real drive cycle. The other byte of each pair is a no-op for the drive. Host signals are taken as synchronous to `clk`; the holding register is clocked and all decode and steering is combinational.

Top module: `isa_ide_bridge`

## Requirements
- R1: The block is selected only when I/O address bits [9:5] equal 16 + base_sel (base = 200h + 20h*base_sel), isa_addr[19] is 0 and isa_aen is 0. While not selected, both chip selects and both drive strobes stay high (inactive), ide_da is 0, and isa_d_oe and ide_d_oe are 0.
- R2: Read strobes are honoured only at offsets 00h-0Fh and write strobes only at offsets 10h-1Fh. A read strobe in the write half, or a write strobe in the read half, gives no drive strobe, no isa_d_oe and no ide_d_oe.
- R3: A read at offset 00h drives ide_cs0_n=0, ide_cs1_n=1 and ide_da=0. ide_dior_n follows isa_ior_n, isa_d_out equals ide_dl_in with isa_d_oe=1, and ide_dh_in is loaded into the holding register at each clock edge the strobe is low.
- R4: A read at offset 01h drives ide_cs0_n=1, ide_cs1_n=0 and ide_da=0, so the drive ignores the cycle. isa_d_out shows the holding register with isa_d_oe=1.
- R5: A write at offset 10h drives ide_cs0_n=1, ide_cs1_n=0 and ide_da=0. isa_d_in is loaded into the holding register at each clock edge the strobe is low.
- R6: A write at offset 11h drives ide_cs0_n=0, ide_cs1_n=1 and ide_da=0. ide_diow_n follows isa_iow_n, ide_d_oe=1, ide_dl_out shows the holding register and ide_dh_out equals isa_d_in.
- R7: Offsets 02h-07h (reads) and 12h-17h (writes) reach command registers with ide_cs0_n=0 and ide_da=A[2:0]. A read returns ide_dl_in; a write drives isa_d_in on ide_dl_out.
- R8: Offsets 08h and 0Ah-0Eh (and 18h, 1Ah-1Eh) drive ide_cs1_n=0 with ide_da=A[2:0]. Offsets 09h and 19h drive ide_cs0_n=0 with ide_da=1 (the error/feature register).
- R9: A read at offset 0Fh returns the byte 04h with no chip select and no drive strobe. A write at offset 1Fh causes no drive activity.
- R10: Chip selects and ide_da depend only on the address, aen and base_sel, so they are valid before and after a strobe. ide_cs0_n and ide_cs1_n are never low together, and a drive strobe is low only while the matching host strobe is low.
- R11: The holding register resets to 00h and keeps its value until the next load at offset 00h (read) or 10h (write).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the holding register |
| rst_n | input | 1 | Active-low synchronous reset |
| isa_addr | input | 20 | ISA address bus |
| isa_aen | input | 1 | Address enable, high during DMA cycles |
| isa_ior_n | input | 1 | Host I/O read strobe, active low |
| isa_iow_n | input | 1 | Host I/O write strobe, active low |
| isa_d_in | input | 8 | Host data toward the drive |
| isa_d_out | output | 8 | Data returned to the host |
| isa_d_oe | output | 1 | Enable for the host data buffer |
| base_sel | input | 4 | Base-address switches |
| ide_cs0_n | output | 1 | Drive command-block select, active low |
| ide_cs1_n | output | 1 | Drive control-block select, active low |
| ide_da | output | 3 | Drive register address |
| ide_dior_n | output | 1 | Drive read strobe, active low |
| ide_diow_n | output | 1 | Drive write strobe, active low |
| ide_dl_in | input | 8 | Drive data bits 7:0 from the drive |
| ide_dh_in | input | 8 | Drive data bits 15:8 from the drive |
| ide_dl_out | output | 8 | Drive data bits 7:0 toward the drive |
| ide_dh_out | output | 8 | Drive data bits 15:8 toward the drive |
| ide_d_oe | output | 1 | Enable for the drive data buffers |

## Verification
Directed pairs cover the byte ordering. A read of 00h followed by 01h shows that the high byte crosses through the holding register. A write of 10h followed by 11h shows that the swapped chip selects put the drive cycle on the second byte. Boundary windows (base_sel 0 and 15), A19 or AEN high, and strobes in the wrong half separate a correct decode from one that ignores A19, AEN or A4. Random vectors of mixed address, strobe and data, with a reference model that tracks the holding register across the sequence, show whether stale latched bytes or swapped selects ever leak to the outputs.

// File: rtl/ibr_pkg.sv
package ibr_pkg;

    typedef enum logic [2:0] {
        RK_NONE    = 3'd0,
        RK_PAIR_LO = 3'd1,
        RK_PAIR_HI = 3'd2,
        RK_CMD     = 3'd3,
        RK_CTRL    = 3'd4,
        RK_ID      = 3'd5
    } reg_kind_e;

    typedef struct packed {
        logic      hit;
        logic      wr;
        reg_kind_e kind;
        logic      cs0;
        logic      cs1;
        logic [2:0] da;
    } sel_t;

    localparam int unsigned WIN_BITS = 5;   // 32-port window

endpackage

// File: rtl/ibr_decode.sv
module ibr_decode
    import ibr_pkg::*;
#(
    parameter int unsigned A_W      = 20,
    parameter int unsigned IO_W     = 10,
    parameter int unsigned SW_W     = 4,
    parameter logic [9:0]  BASE_MIN = 10'h200
) (
    input  logic [A_W-1:0]  addr,
    input  logic            aen,
    input  logic [SW_W-1:0] base_sel,
    output sel_t            sel
);
    localparam int unsigned BLK_W = IO_W - WIN_BITS;
    localparam logic [BLK_W:0] BASE_BLK = {1'b0, BASE_MIN[IO_W-1:WIN_BITS]};

    logic [BLK_W:0]    blk_want;
    logic              match;
    logic [3:0]        idx;
    logic              dir_wr;
    logic              unused_hi;

    assign unused_hi = ^addr[A_W-2:IO_W];
    assign blk_want  = BASE_BLK + (BLK_W+1)'(base_sel);
    assign match     = !addr[A_W-1] && !aen
                       && ({1'b0, addr[IO_W-1:WIN_BITS]} == blk_want);
    assign idx       = addr[3:0];
    assign dir_wr    = addr[4];

    always_comb begin
        sel.hit  = match;
        sel.wr   = dir_wr;
        sel.kind = RK_NONE;
        sel.cs0  = 1'b0;
        sel.cs1  = 1'b0;
        sel.da   = 3'd0;
        if (match) begin
            unique case (idx)
                4'h0: begin
                    sel.kind = RK_PAIR_LO;
                    sel.cs0  = !dir_wr;   // read: real transfer
                    sel.cs1  = dir_wr;    // write: parked, drive ignores
                end
                4'h1: begin
                    sel.kind = RK_PAIR_HI;
                    sel.cs0  = dir_wr;
                    sel.cs1  = !dir_wr;
                end
                4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7: begin
                    sel.kind = RK_CMD;
                    sel.cs0  = 1'b1;
                    sel.da   = idx[2:0];
                end
                4'h9: begin
                    sel.kind = RK_CMD;
                    sel.cs0  = 1'b1;
                    sel.da   = 3'd1;
                end
                4'hF: begin
                    sel.kind = RK_ID;
                end
                default: begin
                    sel.kind = RK_CTRL;
                    sel.cs1  = 1'b1;
                    sel.da   = idx[2:0];
                end
            endcase
        end
    end

endmodule

// File: rtl/ibr_pair_latch.sv
module ibr_pair_latch #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_en,
    input  logic [DW-1:0] ld_val,
    output logic [DW-1:0] data_q
);
    typedef struct packed {
        logic [DW-1:0] byte_v;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ld_en) st_d.byte_v = ld_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data_q = st_q.byte_v;

    // R11: a load lands on the next edge, otherwise the byte holds
    a_r11_load: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> (data_q == $past(ld_val)));
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_en |=> $stable(data_q));

endmodule

// File: rtl/ibr_steer.sv
module ibr_steer
    import ibr_pkg::*;
#(
    parameter int unsigned DW     = 8,
    parameter logic [7:0]  DEV_ID = 8'h04
) (
    input  sel_t          sel,
    input  logic          ior_n,
    input  logic          iow_n,
    input  logic [DW-1:0] host_d,
    input  logic [DW-1:0] drv_lo,
    input  logic [DW-1:0] drv_hi,
    input  logic [DW-1:0] held,
    output logic          dior_n,
    output logic          diow_n,
    output logic [DW-1:0] host_q,
    output logic          host_oe,
    output logic [DW-1:0] out_lo,
    output logic [DW-1:0] out_hi,
    output logic          drv_oe,
    output logic          ld_en,
    output logic [DW-1:0] ld_val
);
    logic rd_go, wr_go, to_drive;

    assign rd_go    = sel.hit && !sel.wr && !ior_n;
    assign wr_go    = sel.hit &&  sel.wr && !iow_n;
    assign to_drive = (sel.kind != RK_ID);

    assign dior_n  = !(rd_go && to_drive);
    assign diow_n  = !(wr_go && to_drive);
    assign host_oe = rd_go;
    assign drv_oe  = wr_go && to_drive;

    always_comb begin
        unique case (sel.kind)
            RK_ID:      host_q = DW'(DEV_ID);
            RK_PAIR_HI: host_q = held;
            RK_NONE:    host_q = '0;
            default:    host_q = drv_lo;
        endcase
    end

    assign out_lo = (sel.kind == RK_PAIR_HI) ? held : host_d;
    assign out_hi = host_d;

    assign ld_en  = (sel.kind == RK_PAIR_LO) && (rd_go || wr_go);
    assign ld_val = sel.wr ? host_d : drv_hi;

endmodule

// File: rtl/isa_ide_bridge.sv
module isa_ide_bridge
    import ibr_pkg::*;
#(
    parameter int unsigned A_W      = 20,
    parameter int unsigned IO_W     = 10,
    parameter int unsigned SW_W     = 4,
    parameter int unsigned DW       = 8,
    parameter logic [9:0]  BASE_MIN = 10'h200,
    parameter logic [7:0]  DEV_ID   = 8'h04
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [A_W-1:0]  isa_addr,
    input  logic            isa_aen,
    input  logic            isa_ior_n,
    input  logic            isa_iow_n,
    input  logic [DW-1:0]   isa_d_in,
    output logic [DW-1:0]   isa_d_out,
    output logic            isa_d_oe,
    input  logic [SW_W-1:0] base_sel,
    output logic            ide_cs0_n,
    output logic            ide_cs1_n,
    output logic [2:0]      ide_da,
    output logic            ide_dior_n,
    output logic            ide_diow_n,
    input  logic [DW-1:0]   ide_dl_in,
    input  logic [DW-1:0]   ide_dh_in,
    output logic [DW-1:0]   ide_dl_out,
    output logic [DW-1:0]   ide_dh_out,
    output logic            ide_d_oe
);
    sel_t          sel;
    logic          ld_en;
    logic [DW-1:0] ld_val;
    logic [DW-1:0] held_q;

    ibr_decode #(
        .A_W(A_W), .IO_W(IO_W), .SW_W(SW_W), .BASE_MIN(BASE_MIN)
    ) u_decode (
        .addr(isa_addr), .aen(isa_aen), .base_sel(base_sel), .sel(sel)
    );

    assign ide_cs0_n = !sel.cs0;
    assign ide_cs1_n = !sel.cs1;
    assign ide_da    = sel.da;

    ibr_steer #(.DW(DW), .DEV_ID(DEV_ID)) u_steer (
        .sel(sel), .ior_n(isa_ior_n), .iow_n(isa_iow_n),
        .host_d(isa_d_in), .drv_lo(ide_dl_in), .drv_hi(ide_dh_in),
        .held(held_q),
        .dior_n(ide_dior_n), .diow_n(ide_diow_n),
        .host_q(isa_d_out), .host_oe(isa_d_oe),
        .out_lo(ide_dl_out), .out_hi(ide_dh_out), .drv_oe(ide_d_oe),
        .ld_en(ld_en), .ld_val(ld_val)
    );

    ibr_pair_latch #(.DW(DW)) u_latch (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_val(ld_val),
        .data_q(held_q)
    );

    // R10: the two selects never overlap
    a_r10_cs_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ide_cs0_n && !ide_cs1_n));
    // R10: drive strobes only under the matching host strobe
    a_r10_dior_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !ide_dior_n |-> !isa_ior_n);
    a_r10_diow_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !ide_diow_n |-> !isa_iow_n);
    // R1: DMA cycles and the upper address half stay quiet
    a_r1_quiet_off: assert property (@(posedge clk) disable iff (!rst_n)
        (isa_aen || isa_addr[A_W-1]) |->
        (ide_cs0_n && ide_cs1_n && ide_dior_n && ide_diow_n && !isa_d_oe && !ide_d_oe));
    // R9: a host read with no drive strobe can only be the ID byte
    a_r9_id_value: assert property (@(posedge clk) disable iff (!rst_n)
        (isa_d_oe && ide_dior_n) |-> (isa_d_out == DW'(DEV_ID)));
    // R3: a real drive read with register 0 passes the low byte to the host
    a_r3_low_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (!ide_dior_n && !ide_cs0_n && ide_da == 3'd0) |-> (isa_d_out == ide_dl_in));

endmodule

// File: tb/isa_ide_bridge_tb.sv
`timescale 1ns/1ps
module isa_ide_bridge_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] isa_addr = '0;
    logic        isa_aen = 1'b0, isa_ior_n = 1'b1, isa_iow_n = 1'b1;
    logic [7:0]  isa_d_in = '0, isa_d_out;
    logic        isa_d_oe;
    logic [3:0]  base_sel = '0;
    logic        ide_cs0_n, ide_cs1_n, ide_dior_n, ide_diow_n, ide_d_oe;
    logic [2:0]  ide_da;
    logic [7:0]  ide_dl_in = '0, ide_dh_in = '0, ide_dl_out, ide_dh_out;

    int checks = 0, fails = 0;
    logic [7:0] m_latch = 8'h00;
    bit done = 0;

    always #5 clk = ~clk;

    isa_ide_bridge dut_i (
        .clk(clk), .rst_n(rst_n), .isa_addr(isa_addr), .isa_aen(isa_aen),
        .isa_ior_n(isa_ior_n), .isa_iow_n(isa_iow_n), .isa_d_in(isa_d_in),
        .isa_d_out(isa_d_out), .isa_d_oe(isa_d_oe), .base_sel(base_sel),
        .ide_cs0_n(ide_cs0_n), .ide_cs1_n(ide_cs1_n), .ide_da(ide_da),
        .ide_dior_n(ide_dior_n), .ide_diow_n(ide_diow_n),
        .ide_dl_in(ide_dl_in), .ide_dh_in(ide_dh_in),
        .ide_dl_out(ide_dl_out), .ide_dh_out(ide_dh_out), .ide_d_oe(ide_d_oe)
    );

    typedef struct packed {
        logic cs0_n, cs1_n;
        logic [2:0] da;
        logic dior_n, diow_n, host_oe, drv_oe;
        logic [7:0] host_q, lo, hi;
        logic ld;
        logic [7:0] ld_v;
    } exp_t;

    function automatic exp_t model(logic [19:0] a, logic aen, logic rn, logic wn,
                                   logic [7:0] din, logic [7:0] dl, logic [7:0] dh,
                                   logic [3:0] sw, logic [7:0] lat);
        exp_t e;
        logic hit, wr, rd_go, wr_go;
        logic [3:0] ix;
        hit = !a[19] && !aen && (a[9:5] == 5'(16 + sw));
        wr = a[4]; ix = a[3:0];
        e = '0; e.cs0_n = 1; e.cs1_n = 1; e.dior_n = 1; e.diow_n = 1;
        if (hit) begin
            if (ix == 4'h0)      begin if (wr) e.cs1_n = 0; else e.cs0_n = 0; end
            else if (ix == 4'h1) begin if (wr) e.cs0_n = 0; else e.cs1_n = 0; end
            else if (ix <= 4'h7) begin e.cs0_n = 0; e.da = ix[2:0]; end
            else if (ix == 4'h9) begin e.cs0_n = 0; e.da = 3'd1; end
            else if (ix != 4'hF) begin e.cs1_n = 0; e.da = ix[2:0]; end
        end
        rd_go = hit && !wr && !rn;
        wr_go = hit && wr && !wn;
        e.dior_n  = !(rd_go && ix != 4'hF);
        e.diow_n  = !(wr_go && ix != 4'hF);
        e.host_oe = rd_go;
        e.drv_oe  = wr_go && ix != 4'hF;
        e.host_q  = (ix == 4'hF) ? 8'h04 : (ix == 4'h1) ? lat : dl;
        e.lo      = (ix == 4'h1) ? lat : din;
        e.hi      = din;
        e.ld      = (ix == 4'h0) && (rd_go || wr_go);
        e.ld_v    = wr ? din : dh;
        return e;
    endfunction

    function automatic string req_of(logic [19:0] a, logic aen, logic [3:0] sw);
        if (a[19] || aen || a[9:5] != 5'(16 + sw)) return "R1";
        case (a[3:0])
            4'h0: return a[4] ? "R5" : "R3";
            4'h1: return a[4] ? "R6" : "R4";
            4'h8, 4'h9, 4'hA, 4'hB, 4'hC, 4'hD, 4'hE: return "R8";
            4'hF: return "R9";
            default: return "R7";
        endcase
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic apply(logic [19:0] a, logic aen, logic rn, logic wn,
                         logic [7:0] din, logic [7:0] dl, logic [7:0] dh,
                         logic [3:0] sw, string tag);
        exp_t e;
        @(negedge clk);
        isa_addr = a; isa_aen = aen; isa_ior_n = rn; isa_iow_n = wn;
        isa_d_in = din; ide_dl_in = dl; ide_dh_in = dh; base_sel = sw;
        #2;
        e = model(a, aen, rn, wn, din, dl, dh, sw, m_latch);
        chk(tag, "ctl", {ide_cs0_n, ide_cs1_n, ide_da, ide_dior_n, ide_diow_n, isa_d_oe, ide_d_oe},
            {e.cs0_n, e.cs1_n, e.da, e.dior_n, e.diow_n, e.host_oe, e.drv_oe});
        if (e.host_oe) chk(tag, "host data", isa_d_out, e.host_q);
        if (e.drv_oe)  chk(tag, "drive data", {ide_dl_out, ide_dh_out}, {e.lo, e.hi});
        @(posedge clk);
        if (e.ld) m_latch = e.ld_v;
    endtask

    task automatic idle();
        apply(20'h00000, 0, 1, 1, 8'h00, 8'h00, 8'h00, 4'h8, "R1");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // reset state (R1, R11): idle decode, latch reads back 00h
        idle();
        apply(20'h00301, 0, 0, 1, 8'h00, 8'hEE, 8'hEE, 4'h8, "R11");
        // read pair (R3, R4)
        apply(20'h00300, 0, 0, 1, 8'h00, 8'hA5, 8'h5A, 4'h8, "R3");
        apply(20'h00300, 0, 1, 1, 8'h00, 8'hA5, 8'h5A, 4'h8, "R10");
        apply(20'h00301, 0, 0, 1, 8'h00, 8'h00, 8'h00, 4'h8, "R4");
        // write pair (R5, R6)
        apply(20'h00310, 0, 1, 0, 8'h11, 8'h00, 8'h00, 4'h8, "R5");
        apply(20'h00311, 0, 1, 0, 8'h22, 8'h00, 8'h00, 4'h8, "R6");
        // latch keeps last load across other accesses (R11)
        apply(20'h00307, 0, 0, 1, 8'h00, 8'h77, 8'h99, 4'h8, "R7");
        apply(20'h00301, 0, 0, 1, 8'h00, 8'h00, 8'h00, 4'h8, "R11");
        apply(20'h00316, 0, 1, 0, 8'h3C, 8'h00, 8'h00, 4'h8, "R7");
        // control block and feature register (R8)
        apply(20'h0030E, 0, 0, 1, 8'h00, 8'h50, 8'h00, 4'h8, "R8");
        apply(20'h00309, 0, 0, 1, 8'h00, 8'h04, 8'h00, 4'h8, "R8");
        apply(20'h00318, 0, 1, 0, 8'h0C, 8'h00, 8'h00, 4'h8, "R8");
        // ID byte (R9)
        apply(20'h0030F, 0, 0, 1, 8'h00, 8'hFF, 8'hFF, 4'h8, "R9");
        apply(20'h0031F, 0, 1, 0, 8'hAB, 8'h00, 8'h00, 4'h8, "R9");
        // wrong-half strobes (R2)
        apply(20'h00311, 0, 0, 1, 8'h00, 8'h12, 8'h34, 4'h8, "R2");
        apply(20'h00300, 0, 1, 0, 8'h56, 8'h00, 8'h00, 4'h8, "R2");
        // window edges and exclusions (R1)
        apply(20'h00200, 0, 0, 1, 8'h00, 8'h61, 8'h62, 4'h0, "R1");
        apply(20'h003E1, 0, 0, 1, 8'h00, 8'h00, 8'h00, 4'hF, "R1");
        apply(20'h003E0, 0, 0, 1, 8'h00, 8'h71, 8'h72, 4'hE, "R1");
        apply(20'h80300, 0, 0, 1, 8'h00, 8'h81, 8'h82, 4'h8, "R1");
        apply(20'h00300, 1, 0, 1, 8'h00, 8'h91, 8'h92, 4'h8, "R1");
        apply(20'h7F301, 0, 0, 1, 8'h00, 8'h00, 8'h00, 4'h8, "R4");
        // random mix
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4000; i++) begin
            logic [19:0] a;
            logic [3:0]  sw;
            logic        aen, rn, wn;
            logic [1:0]  st;
            sw = 4'($urandom);
            a  = 20'($urandom);
            if ($urandom_range(9) < 8) begin
                a[9:5] = 5'(16 + sw);
                a[19]  = ($urandom_range(15) == 0);
            end
            aen = ($urandom_range(11) == 0);
            st  = 2'($urandom_range(2));
            rn  = (st != 2'd1);
            wn  = (st != 2'd2);
            apply(a, aen, rn, wn, 8'($urandom), 8'($urandom), 8'($urandom), sw,
                  req_of(a, aen, sw));
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule